// File: doc/BRIEF.md
# DMA Error Collector with Combined Interrupt

This block gathers the error conditions of a DMA channel controller into sticky status registers and raises one level-sensitive error interrupt whenever any of them is recorded. Four kinds of error feed it: a missed event on a normal DMA channel, a missed event on a quick-DMA channel, a transfer completion code error, and a threshold-exceeded condition on either of two transfer queues. A missed event is detected when a new event arrives on a channel whose previous event is still pending. The pending flags come from the event logic next to this block.

No error source can be masked. Each recorded bit holds until software clears it by writing a one to that bit through a simple clear-write port, and the interrupt stays high for as long as any status bit is set. The three status registers (normal-channel misses, quick-channel misses and a combined controller error word) are brought out as ports, so the surrounding register file can expose them as read-only.

Top module: `dma_err_collect`

## Requirements
- R1: After reset every status bit is 0 and `err_irq_o` is low.
- R2: A cycle with `dma_evt_i[c]` and `dma_pend_i[c]` both high sets `dma_miss_o[c]` at the next clock edge. An event without a pending flag, or a pending flag without an event, sets nothing.
- R3: A cycle with `qdma_evt_i[c]` and `qdma_pend_i[c]` both high sets `qdma_miss_o[c]` at the next clock edge, following the same rule as R2.
- R4: A high `tcc_err_i` sets bit 16 of `cc_err_o` at the next clock edge.
- R5: A high `qthr_i[n]` sets bit n of `cc_err_o` (n = 0, 1) at the next clock edge. All other bits of `cc_err_o` always read 0.
- R6: Every status bit is sticky. Once set, it stays set until it is cleared.
- R7: With `clr_we_i` high, each 1 in `clr_data_i` clears the matching status bit at the next edge, and 0 bits leave their status bits unchanged. `clr_sel_i` picks the register: 0 for normal-channel misses, 1 for quick-channel misses, 2 for the controller error word (bit positions as in R4/R5). Selector 3, or `clr_we_i` low, clears nothing.
- R8: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `err_irq_o` is high exactly when at least one status bit is set, and it changes in the same cycle as the status ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_evt_i | input | NUM_CH | Event arrival pulse per normal DMA channel |
| dma_pend_i | input | NUM_CH | Event already pending per normal DMA channel |
| qdma_evt_i | input | NUM_QCH | Event arrival pulse per quick-DMA channel |
| qdma_pend_i | input | NUM_QCH | Event already pending per quick-DMA channel |
| tcc_err_i | input | 1 | Transfer completion code error pulse |
| qthr_i | input | NUM_Q | Queue threshold-exceeded pulse per queue |
| clr_we_i | input | 1 | Clear-write strobe |
| clr_sel_i | input | 2 | Register selected for clearing |
| clr_data_i | input | 32 | Write-one-to-clear mask |
| dma_miss_o | output | NUM_CH | Sticky missed-event flags, normal channels |
| qdma_miss_o | output | NUM_QCH | Sticky missed-event flags, quick channels |
| cc_err_o | output | 32 | Controller error word (bit 16 completion code, bits 1:0 queues) |
| err_irq_o | output | 1 | Combined error interrupt, level |

## Verification
Each normal and quick channel is driven in turn with all four combinations of event and pending flag. This shows that only the coincidence sets a bit, and only the addressed bit. Every controller error source is pulsed alone and then cleared. Clears are tried with single-bit, multi-bit and all-ones masks under every selector value and with the strobe low, which separates correct decoding from clears that leak into the wrong register. Simultaneous set and clear on one bit shows the priority, and the interrupt is compared on every cycle, so a late or stuck interrupt shows up against the status ports.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned TCC_BIT_POS = 16;

    typedef enum logic [1:0] {
        CLR_DMA_MISS  = 2'd0,
        CLR_QDMA_MISS = 2'd1,
        CLR_CC_ERR    = 2'd2,
        CLR_NONE      = 2'd3
    } clr_sel_e;

endpackage

// File: rtl/dma_miss_detect.sv
module dma_miss_detect #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] pend_i,
    output logic [W-1:0] miss_o
);
    // A channel misses an event when a new one lands while one is pending.
    for (genvar g = 0; g < W; g++) begin : g_ch
        assign miss_o[g] = evt_i[g] & pend_i[g];
    end
endmodule

// File: rtl/dma_clr_decode.sv
module dma_clr_decode
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_QCH = 4,
    parameter int unsigned NUM_Q   = 2
) (
    input  logic                 we_i,
    input  logic [1:0]           sel_i,
    input  logic [REG_W-1:0]     data_i,
    output logic [NUM_CH-1:0]    clr_dma_o,
    output logic [NUM_QCH-1:0]   clr_qdma_o,
    output logic [NUM_Q:0]       clr_cc_o
);
    localparam int unsigned CC_W = NUM_Q + 1;

    logic [CC_W-1:0] cc_mask;

    // Controller error bank: queues at [NUM_Q-1:0], completion code on top.
    for (genvar q = 0; q < NUM_Q; q++) begin : g_qmask
        assign cc_mask[q] = data_i[q];
    end
    assign cc_mask[NUM_Q] = data_i[TCC_BIT_POS];

    always_comb begin
        clr_dma_o  = '0;
        clr_qdma_o = '0;
        clr_cc_o   = '0;
        if (we_i) begin
            unique case (clr_sel_e'(sel_i))
                CLR_DMA_MISS:  clr_dma_o  = data_i[NUM_CH-1:0];
                CLR_QDMA_MISS: clr_qdma_o = data_i[NUM_QCH-1:0];
                CLR_CC_ERR:    clr_cc_o   = cc_mask;
                default:       ;
            endcase
        end
    end

    logic unused_data;
    assign unused_data = ^data_i;
endmodule

// File: rtl/dma_sticky_bank.sv
module dma_sticky_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] bits_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } bank_t;

    bank_t st_d, st_q;

    // Set has priority over clear on the same bit.
    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bits_o = st_q.bits;
endmodule

// File: rtl/dma_err_collect.sv
module dma_err_collect
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_QCH = 4,
    parameter int unsigned NUM_Q   = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_CH-1:0]    dma_evt_i,
    input  logic [NUM_CH-1:0]    dma_pend_i,
    input  logic [NUM_QCH-1:0]   qdma_evt_i,
    input  logic [NUM_QCH-1:0]   qdma_pend_i,
    input  logic                 tcc_err_i,
    input  logic [NUM_Q-1:0]     qthr_i,
    input  logic                 clr_we_i,
    input  logic [1:0]           clr_sel_i,
    input  logic [31:0]          clr_data_i,
    output logic [NUM_CH-1:0]    dma_miss_o,
    output logic [NUM_QCH-1:0]   qdma_miss_o,
    output logic [31:0]          cc_err_o,
    output logic                 err_irq_o
);
    localparam int unsigned CC_W = NUM_Q + 1;

    logic [NUM_CH-1:0]  set_dma,  clr_dma;
    logic [NUM_QCH-1:0] set_qdma, clr_qdma;
    logic [CC_W-1:0]    set_cc,   clr_cc, cc_bits;

    dma_miss_detect #(.W(NUM_CH)) u_dma_miss (
        .evt_i (dma_evt_i),
        .pend_i(dma_pend_i),
        .miss_o(set_dma)
    );

    dma_miss_detect #(.W(NUM_QCH)) u_qdma_miss (
        .evt_i (qdma_evt_i),
        .pend_i(qdma_pend_i),
        .miss_o(set_qdma)
    );

    assign set_cc = {tcc_err_i, qthr_i};

    dma_clr_decode #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q)) u_clr (
        .we_i      (clr_we_i),
        .sel_i     (clr_sel_i),
        .data_i    (clr_data_i),
        .clr_dma_o (clr_dma),
        .clr_qdma_o(clr_qdma),
        .clr_cc_o  (clr_cc)
    );

    dma_sticky_bank #(.W(NUM_CH)) u_dma_bank (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .set_i (set_dma), .clr_i(clr_dma), .bits_o(dma_miss_o)
    );

    dma_sticky_bank #(.W(NUM_QCH)) u_qdma_bank (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .set_i (set_qdma), .clr_i(clr_qdma), .bits_o(qdma_miss_o)
    );

    dma_sticky_bank #(.W(CC_W)) u_cc_bank (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .set_i (set_cc), .clr_i(clr_cc), .bits_o(cc_bits)
    );

    // Place the compact controller bank into its 32-bit word.
    for (genvar b = 0; b < REG_W; b++) begin : g_ccword
        if (b < NUM_Q) begin : g_q
            assign cc_err_o[b] = cc_bits[b];
        end else if (b == TCC_BIT_POS) begin : g_tcc
            assign cc_err_o[b] = cc_bits[NUM_Q];
        end else begin : g_zero
            assign cc_err_o[b] = 1'b0;
        end
    end

    // No per-source enables: any recorded error raises the interrupt.
    assign err_irq_o = (|dma_miss_o) | (|qdma_miss_o) | (|cc_bits);
endmodule

// File: rtl/dma_err_collect_chk.sv
module dma_err_collect_chk
    import dma_err_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_QCH = 4,
    parameter int unsigned NUM_Q   = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_CH-1:0]    dma_evt_i,
    input logic [NUM_CH-1:0]    dma_pend_i,
    input logic [NUM_QCH-1:0]   qdma_evt_i,
    input logic [NUM_QCH-1:0]   qdma_pend_i,
    input logic                 tcc_err_i,
    input logic [NUM_Q-1:0]     qthr_i,
    input logic                 clr_we_i,
    input logic [1:0]           clr_sel_i,
    input logic [31:0]          clr_data_i,
    input logic [NUM_CH-1:0]    dma_miss_o,
    input logic [NUM_QCH-1:0]   qdma_miss_o,
    input logic [31:0]          cc_err_o,
    input logic                 err_irq_o
);
    p_dma_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((dma_miss_o & $past(dma_evt_i & dma_pend_i)) == $past(dma_evt_i & dma_pend_i)));

    p_qdma_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((qdma_miss_o & $past(qdma_evt_i & qdma_pend_i)) == $past(qdma_evt_i & qdma_pend_i)));

    p_tcc_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tcc_err_i |=> cc_err_o[TCC_BIT_POS]);

    p_qthr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cc_err_o[NUM_Q-1:0] & $past(qthr_i)) == $past(qthr_i)));

    p_dma_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(clr_we_i && clr_sel_i == CLR_DMA_MISS) |=>
        ((dma_miss_o & $past(dma_miss_o)) == $past(dma_miss_o)));

    p_tcc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_we_i && clr_sel_i == CLR_CC_ERR && clr_data_i[TCC_BIT_POS] && !tcc_err_i)
        |=> !cc_err_o[TCC_BIT_POS]);

    p_irq_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|dma_miss_o) || (|qdma_miss_o) || (|cc_err_o)) |-> err_irq_o);

    p_irq_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_irq_o |-> (dma_miss_o == '0 && qdma_miss_o == '0 && cc_err_o == '0));
endmodule

bind dma_err_collect dma_err_collect_chk #(
    .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .NUM_Q(NUM_Q)
) chk_i (.*);

// File: tb/dma_err_collect_tb_top.sv
module dma_err_collect_tb_top;
    localparam int NCH = 8;
    localparam int NQC = 4;
    localparam int NQ  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] dma_evt = '0, dma_pend = '0;
    logic [NQC-1:0] qdma_evt = '0, qdma_pend = '0;
    logic           tcc = 1'b0;
    logic [NQ-1:0]  qthr = '0;
    logic           we = 1'b0;
    logic [1:0]     sel = 2'd3;
    logic [31:0]    wdata = '0;
    logic [NCH-1:0] dma_miss;
    logic [NQC-1:0] qdma_miss;
    logic [31:0]    cc_err;
    logic           irq;

    int n_checks = 0;
    int n_fails  = 0;
    logic [NCH-1:0] exp_dma  = '0;
    logic [NQC-1:0] exp_qdma = '0;
    logic [31:0]    exp_cc   = '0;

    always #5 clk = ~clk;

    dma_err_collect #(.NUM_CH(NCH), .NUM_QCH(NQC), .NUM_Q(NQ)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .dma_evt_i(dma_evt), .dma_pend_i(dma_pend),
        .qdma_evt_i(qdma_evt), .qdma_pend_i(qdma_pend),
        .tcc_err_i(tcc), .qthr_i(qthr),
        .clr_we_i(we), .clr_sel_i(sel), .clr_data_i(wdata),
        .dma_miss_o(dma_miss), .qdma_miss_o(qdma_miss),
        .cc_err_o(cc_err), .err_irq_o(irq)
    );

    task automatic compare(input string tag);
        logic exp_irq;
        exp_irq = (|exp_dma) | (|exp_qdma) | (|exp_cc);
        n_checks++;
        if (dma_miss !== exp_dma || qdma_miss !== exp_qdma || cc_err !== exp_cc || irq !== exp_irq) begin
            n_fails++;
            $display("FAIL %s: dma=%h/%h qdma=%h/%h cc=%h/%h irq=%b/%b (actual/expected)",
                     tag, dma_miss, exp_dma, qdma_miss, exp_qdma, cc_err, exp_cc, irq, exp_irq);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks the result.
    task automatic step(input logic [NCH-1:0] de, input logic [NCH-1:0] dp,
                        input logic [NQC-1:0] qe, input logic [NQC-1:0] qp,
                        input logic t, input logic [NQ-1:0] qt,
                        input logic w, input logic [1:0] s, input logic [31:0] d,
                        input string tag);
        logic [31:0] cset, cclr;
        dma_evt = de; dma_pend = dp; qdma_evt = qe; qdma_pend = qp;
        tcc = t; qthr = qt; we = w; sel = s; wdata = d;
        // Expected next state from R2..R8: clear selected bits, then apply sets.
        cset = '0; cset[16] = t; cset[NQ-1:0] = qt;
        cclr = (w && s == 2'd2) ? (d & 32'h0001_0003) : '0;
        if (w && s == 2'd0) exp_dma  = exp_dma  & ~d[NCH-1:0];
        if (w && s == 2'd1) exp_qdma = exp_qdma & ~d[NQC-1:0];
        exp_dma  = exp_dma  | (de & dp);
        exp_qdma = exp_qdma | (qe & qp);
        exp_cc   = (exp_cc & ~cclr) | cset;
        @(posedge clk); #1;
        compare(tag);
        @(negedge clk);
        dma_evt = '0; dma_pend = '0; qdma_evt = '0; qdma_pend = '0;
        tcc = 1'b0; qthr = '0; we = 1'b0; sel = 2'd3; wdata = '0;
    endtask

    task automatic idle(input string tag);
        step('0, '0, '0, '0, 1'b0, '0, 1'b0, 2'd3, '0, tag);
    endtask

    task automatic wclr(input logic [1:0] s, input logic [31:0] d, input string tag);
        step('0, '0, '0, '0, 1'b0, '0, 1'b1, s, d, tag);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        compare("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // R2: every normal channel, every event/pending combination.
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [NCH-1:0] oh;
                oh = NCH'(1) << c;
                step(p[0] ? oh : '0, p[1] ? oh : '0, '0, '0, 1'b0, '0, 1'b0, 2'd3, '0, "R2 dma miss");
                idle("R6 dma sticky");
                wclr(2'd0, 32'(oh), "R7 dma clear");
            end
        end

        // R3: every quick channel, every combination; pending given on all lanes.
        for (int c = 0; c < NQC; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [NQC-1:0] oh;
                oh = NQC'(1) << c;
                step('0, '0, p[0] ? oh : '0, p[1] ? '1 : '0, 1'b0, '0, 1'b0, 2'd3, '0, "R3 qdma miss");
                idle("R6 qdma sticky");
                wclr(2'd1, 32'(oh), "R7 qdma clear");
            end
        end

        // R4 / R5: controller error sources one at a time.
        step('0, '0, '0, '0, 1'b1, '0, 1'b0, 2'd3, '0, "R4 tcc set");
        idle("R6 tcc sticky");
        wclr(2'd2, 32'h0001_0000, "R7 tcc clear");
        for (int q = 0; q < NQ; q++) begin
            step('0, '0, '0, '0, 1'b0, NQ'(1) << q, 1'b0, 2'd3, '0, "R5 queue threshold set");
            wclr(2'd2, 32'h0000_0000, "R7 zero mask keeps");
            wclr(2'd2, 32'(1) << q, "R7 queue clear");
        end

        // Fill everything, then try clears that must do nothing.
        step('1, '1, '1, '1, 1'b1, '1, 1'b0, 2'd3, '0, "R2 R3 R4 R5 all set");
        wclr(2'd3, 32'hFFFF_FFFF, "R7 selector 3 ignored");
        step('0, '0, '0, '0, 1'b0, '0, 1'b0, 2'd0, 32'hFFFF_FFFF, "R7 strobe low ignored");
        // Clears must not leak across registers.
        wclr(2'd0, 32'h0000_00A5, "R7 dma partial clear");
        wclr(2'd1, 32'h0000_0006, "R7 qdma partial clear");
        wclr(2'd2, 32'hFFFE_FFFF, "R7 cc clear without bit16");
        wclr(2'd0, 32'hFFFF_FFFF, "R7 dma full clear");
        wclr(2'd1, 32'hFFFF_FFFF, "R7 qdma full clear");
        wclr(2'd2, 32'hFFFF_FFFF, "R9 all clear irq low");

        // R8: set and clear on the same bit in the same cycle.
        step(8'h10, 8'h10, '0, '0, 1'b0, '0, 1'b1, 2'd0, 32'h0000_0010, "R8 dma set beats clear");
        step('0, '0, 4'h2, 4'h2, 1'b0, '0, 1'b1, 2'd1, 32'h0000_0002, "R8 qdma set beats clear");
        step('0, '0, '0, '0, 1'b1, 2'b01, 1'b1, 2'd2, 32'h0001_0001, "R8 cc set beats clear");
        wclr(2'd0, 32'hFF, "R7 cleanup dma");
        wclr(2'd1, 32'hF, "R7 cleanup qdma");
        wclr(2'd2, 32'h0001_0003, "R9 cleanup irq low");

        // R9: a single source alone raises the interrupt.
        step('0, '0, '0, '0, 1'b0, 2'b10, 1'b0, 2'd3, '0, "R9 irq from one queue");
        wclr(2'd2, 32'h2, "R9 irq drops");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule